// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is a small cache of page-table translations that sits inside an address translation unit. A 14-bit virtual address arrives on the lookup port. Its upper 8 bits form the virtual page number (VPN), and the low 6 bits are the byte offset inside a 64-byte page. In the same cycle the block reports whether it holds a translation for that page. On a hit it returns the 6-bit physical page number (PPN) and the 3 permission bits stored with it, so that a protection check can be made without a table walk.

On a miss it raises a miss flag for the page-table walker. The walker later writes the fetched entry back through the refill port. Storage holds 16 entries arranged as 4 sets of 4 ways. Each way keeps a tag, a PPN, permission bits and a valid flag. A flush input invalidates every entry at once when the address space changes.

Top module: `tlb_sa`

## Requirements
- R1: The set is selected by lookup address bits 7..6, which are the low 2 bits of the VPN. The tag is taken from address bits 13..8, and refill VPN bits 7..2. Two pages with equal tags in different sets are held and returned independently.
- R2: Address bits 5..0 have no effect on the lookup result.
- R3: With `lk_valid` high, a valid way in the selected set whose tag matches gives `lk_hit`=1 in the same cycle. That hit carries the stored `lk_ppn` and `lk_perm`, with perm bit 0 for read, bit 1 for write and bit 2 for execute.
- R4: With `lk_valid` high and no matching valid way, `lk_miss`=1, `lk_hit`=0, and `lk_ppn` and `lk_perm` read 0. With `lk_valid` low, both `lk_hit` and `lk_miss` are 0.
- R5: A refill becomes visible to lookups from the cycle after `fill_en` is sampled. A lookup of the same VPN in the refill cycle itself reports a miss.
- R6: A refill of a VPN that is not present writes the lowest-numbered invalid way of its set.
- R7: When all four ways of the set are valid, the refill replaces the way named by that set's round-robin pointer. The pointer is 0 after reset and advances by one, wrapping from 3 to 0, after each such replacement. The first replacement in a full set therefore evicts way 0, and the second evicts way 1.
- R8: A refill of a VPN already present overwrites that same way. The set never holds two matching ways, and no other entry is disturbed.
- R9: A sampled `flush` invalidates all 16 entries in one cycle. A refill in the same cycle is discarded.
- R10: After reset every entry is invalid.
- R11: Stored translations change only through refill or flush. With no refill or flush, a constant lookup input gives constant outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request valid |
| lk_va | input | 14 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request valid but translation absent |
| lk_ppn | output | 6 | Physical page number on hit |
| lk_perm | output | 3 | Permission bits on hit |
| fill_en | input | 1 | Refill write strobe |
| fill_vpn | input | 8 | VPN of the refilled entry |
| fill_ppn | input | 6 | PPN of the refilled entry |
| fill_perm | input | 3 | Permission bits of the refilled entry |

## Verification
The assertions assume that reset is applied before the first refill. The visibility property also assumes that nothing except a flush in the refill cycle itself can undo a refill before the next lookup. Since a refill in the very next cycle only writes on the following edge, the stimulus meets this by driving each refill at a falling edge, dropping it one cycle later, and looking up afterwards. The directed tests fill sets to capacity and beyond, rewrite resident pages, and overlap a refill with a lookup or a flush. They also vary offset bits across pages held in different sets, which reaches the replacement, duplicate-avoidance and priority corner cases.

// File: rtl/tlb_sa.sv
module tlb_sa #(
  parameter int VA_W   = 14,
  parameter int PG_W   = 6,
  parameter int SET_W  = 2,
  parameter int WAYS   = 4,
  parameter int PPN_W  = 6,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_en,
  input  logic [VA_W-PG_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm
);
  localparam int VPN_W  = VA_W - PG_W;
  localparam int TAG_W  = VPN_W - SET_W;
  localparam int SETS   = 1 << SET_W;
  localparam int WIDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [PPN_W-1:0]  ppn_q  [SETS][WAYS];
  logic [PERM_W-1:0] perm_q [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WIDX_W-1:0] rr_q    [SETS];

  logic [VPN_W-1:0] lk_vpn;
  logic [SET_W-1:0] lk_set, f_set;
  logic [TAG_W-1:0] lk_tag, f_tag;
  logic [WAYS-1:0]  way_match, f_match, f_free;
  logic             lk_unused_offset;
  logic             same_vpn, any_match;

  assign lk_vpn  = lk_va[VA_W-1:PG_W];
  assign lk_set  = lk_vpn[SET_W-1:0];
  assign lk_tag  = lk_vpn[VPN_W-1:SET_W];
  assign f_set   = fill_vpn[SET_W-1:0];
  assign f_tag   = fill_vpn[VPN_W-1:SET_W];
  assign lk_unused_offset = ^lk_va[PG_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign f_match[w]   = valid_q[f_set][w]  && (tag_q[f_set][w]  == f_tag);
    assign f_free[w]    = !valid_q[f_set][w];
  end

  assign same_vpn  = fill_en && (fill_vpn == lk_vpn);
  assign any_match = |way_match;
  assign lk_hit    = lk_valid && any_match && !same_vpn;
  assign lk_miss   = lk_valid && !lk_hit;

  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit && way_match[w]) begin
        lk_ppn  = lk_ppn  | ppn_q[lk_set][w];
        lk_perm = lk_perm | perm_q[lk_set][w];
      end
    end
  end

  logic [WIDX_W-1:0] victim;
  logic              use_rr;

  always_comb begin
    victim = rr_q[f_set];
    use_rr = 1'b0;
    if (|f_match) begin
      for (int w = 0; w < WAYS; w++)
        if (f_match[w]) victim = WIDX_W'(w);
    end else if (|f_free) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (f_free[w]) victim = WIDX_W'(w);
    end else begin
      use_rr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (fill_en) begin
      tag_q[f_set][victim]   <= f_tag;
      ppn_q[f_set][victim]   <= fill_ppn;
      perm_q[f_set][victim]  <= fill_perm;
      valid_q[f_set][victim] <= 1'b1;
      if (use_rr)
        rr_q[f_set] <= (rr_q[f_set] == WIDX_W'(WAYS - 1)) ? '0 : rr_q[f_set] + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_sa_chk.sv
module tlb_sa_chk #(
  parameter int VA_W   = 14,
  parameter int PG_W   = 6,
  parameter int WAYS   = 4,
  parameter int PPN_W  = 6,
  parameter int PERM_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_va,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic [PPN_W-1:0]  lk_ppn,
  input logic [PERM_W-1:0] lk_perm,
  input logic              fill_en,
  input logic [VA_W-PG_W-1:0] fill_vpn,
  input logic [PPN_W-1:0]  fill_ppn,
  input logic [PERM_W-1:0] fill_perm,
  input logic [WAYS-1:0]   way_match
);
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit); // R9

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match)); // R8

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=>
      (!(lk_valid && lk_va[VA_W-1:PG_W] == $past(fill_vpn) && !fill_en) ||
       (lk_hit && lk_ppn == $past(fill_ppn) && lk_perm == $past(fill_perm)))); // R5

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!fill_en && !flush) && !fill_en && $stable(lk_va) && $stable(lk_valid))
      |-> ($stable(lk_hit) && $stable(lk_ppn) && $stable(lk_perm))); // R11

  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss) && (lk_valid == (lk_hit || lk_miss))); // R4
endmodule

bind tlb_sa tlb_sa_chk #(
  .VA_W(VA_W), .PG_W(PG_W), .WAYS(WAYS), .PPN_W(PPN_W), .PERM_W(PERM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_va(lk_va),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
  .fill_perm(fill_perm), .way_match(way_match)
);

// File: tb/tlb_sa_tb_top.sv
module tlb_sa_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       flush = 0;
  logic       lk_valid = 0;
  logic [13:0] lk_va = '0;
  logic       lk_hit, lk_miss;
  logic [5:0] lk_ppn;
  logic [2:0] lk_perm;
  logic       fill_en = 0;
  logic [7:0] fill_vpn = '0;
  logic [5:0] fill_ppn = '0;
  logic [2:0] fill_perm = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_sa dut_i (.*);

  function automatic logic [7:0] vp(input int tag, input int set);
    return {6'(tag), 2'(set)};
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] v, input logic [5:0] p, input logic [2:0] pm);
    fill_en = 1; fill_vpn = v; fill_ppn = p; fill_perm = pm;
    @(posedge clk); @(negedge clk);
    fill_en = 0;
  endtask

  // checks {hit, miss, ppn, perm} at a quiet point after a falling edge
  task automatic look(input string req, input logic [7:0] v, input logic [5:0] off,
                      input logic h, input logic [5:0] p, input logic [2:0] pm);
    lk_valid = 1; lk_va = {v, off};
    #1;
    chk(req, {lk_hit, lk_miss, lk_ppn, lk_perm}, {h, ~h, h ? p : 6'd0, h ? pm : 3'd0});
    @(negedge clk);
  endtask

  task automatic do_flush();
    flush = 1; @(posedge clk); @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    lk_valid = 0; lk_va = '0; #1;
    chk("R4 idle", {8'd0, lk_hit, lk_miss}, 10'd0);
    for (int s = 0; s < 4; s++) look("R10 empty after reset", vp(0, s), 6'd0, 0, 0, 0);
  endtask

  task automatic t_fill_hit();
    fill(vp(5, 0), 6'h28, 3'b001);
    look("R3 hit data", vp(5, 0), 6'h00, 1, 6'h28, 3'b001);
    look("R4 other tag misses", vp(6, 0), 6'h00, 0, 0, 0);
    look("R2 offset 3F", vp(5, 0), 6'h3F, 1, 6'h28, 3'b001);
    look("R2 offset 15", vp(5, 0), 6'h15, 1, 6'h28, 3'b001);
  endtask

  task automatic t_sets();
    fill(vp(9, 1), 6'h11, 3'b100);
    fill(vp(9, 2), 6'h22, 3'b010);
    look("R1 set1", vp(9, 1), 6'h07, 1, 6'h11, 3'b100);
    look("R1 set2", vp(9, 2), 6'h07, 1, 6'h22, 3'b010);
    look("R1 set3 empty", vp(9, 3), 6'h07, 0, 0, 0);
  endtask

  task automatic t_evict();
    do_flush();
    for (int t = 1; t <= 4; t++) fill(vp(t, 1), 6'(t), 3'b011);
    for (int t = 1; t <= 4; t++) look("R6 four free ways used", vp(t, 1), 6'd0, 1, 6'(t), 3'b011);
    fill(vp(5, 1), 6'd5, 3'b011);
    look("R7 way0 evicted first", vp(1, 1), 6'd0, 0, 0, 0);
    look("R7 new entry", vp(5, 1), 6'd0, 1, 6'd5, 3'b011);
    fill(vp(6, 1), 6'd6, 3'b011);
    look("R7 way1 evicted second", vp(2, 1), 6'd0, 0, 0, 0);
    for (int t = 3; t <= 6; t++) look("R7 survivors", vp(t, 1), 6'd0, 1, 6'(t), 3'b011);
  endtask

  task automatic t_update();
    fill(vp(4, 1), 6'h3A, 3'b111);
    look("R8 rewritten in place", vp(4, 1), 6'd0, 1, 6'h3A, 3'b111);
    look("R8 neighbour kept 3", vp(3, 1), 6'd0, 1, 6'd3, 3'b011);
    look("R8 neighbour kept 5", vp(5, 1), 6'd0, 1, 6'd5, 3'b011);
    look("R8 neighbour kept 6", vp(6, 1), 6'd0, 1, 6'd6, 3'b011);
  endtask

  task automatic t_same_cycle();
    lk_valid = 1; lk_va = {vp(20, 3), 6'h01};
    fill_en = 1; fill_vpn = vp(20, 3); fill_ppn = 6'h0D; fill_perm = 3'b101;
    #1;
    chk("R5 same-cycle miss", {lk_hit, lk_miss, 8'd0}, {1'b0, 1'b1, 8'd0});
    @(posedge clk); @(negedge clk);
    fill_en = 0;
    look("R5 visible next cycle", vp(20, 3), 6'h01, 1, 6'h0D, 3'b101);
  endtask

  task automatic t_flush();
    flush = 1; fill_en = 1; fill_vpn = vp(30, 2); fill_ppn = 6'h2D; fill_perm = 3'b001;
    @(posedge clk); @(negedge clk);
    flush = 0; fill_en = 0;
    look("R9 flushed", vp(20, 3), 6'd0, 0, 0, 0);
    look("R9 flushed set1", vp(5, 1), 6'd0, 0, 0, 0);
    look("R9 refill dropped", vp(30, 2), 6'd0, 0, 0, 0);
    lk_valid = 0; #1;
    chk("R11 quiet", {8'd0, lk_hit, lk_miss}, 10'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_hit();
    t_sets();
    t_evict();
    t_update();
    t_same_cycle();
    t_flush();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule